// File: doc/BRIEF.md
# Registered Nibble-Split Bidirectional Substitution Unit

This block substitutes one byte per clock through two independent 4-bit permutations. The incoming byte and its direction bit are captured together in an input register. The byte is then split into an upper and a lower half, and the two halves are substituted in parallel. The upper half uses box A and the lower half uses box B. Each box has a forward table and the exact inverse of that table. The direction bit picks which of the two tables is used. The two substituted halves are put back in their original positions, and the byte is captured in an output register.

The unit accepts a new transaction on every cycle. A result appears two clock edges after its input. Because every backward table undoes its forward table, sending a forward result back through the unit in backward mode returns the original byte. This makes the unit suitable as the substitution layer of a small cipher, where the same hardware serves both encryption and decryption.

Top module: `nibble_sbox`

## Requirements
- R1: When `valid_i` is high at a rising edge, `data_i` and `mode_i` are captured. The result is presented on `data_o` with `valid_o` high exactly two rising edges after the capture edge. `valid_o` is always `valid_i` delayed by two edges.
- R2: Bits 7:4 are substituted only by box A and bits 3:0 only by box B. Each result half stays in the bit position it came from.
- R3: With `mode_i` = 0 the forward tables apply. Values are listed for inputs 0 to F. Box A: 7,C,0,9,E,3,A,5,1,F,4,B,8,2,D,6. Box B: B,2,E,8,0,D,5,3,F,6,A,1,C,9,4,7.
- R4: With `mode_i` = 1 each half is mapped through the inverse of its box's forward table from R3.
- R5: The direction applied to a transaction is the `mode_i` value sampled with its byte. A change of `mode_i` in a later cycle does not alter a result that is already in flight.
- R6: While `rst_ni` is low, `valid_o` and `data_o` are forced to 0 at once, without waiting for a clock edge.
- R7: In forward mode the byte mapping is a permutation of all 256 values. A forward result fed back in backward mode returns the original byte.
- R8: `data_o` keeps its last value when no transaction completes in a cycle.
- R9: Back-to-back transactions on consecutive cycles each produce their own correct result, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input byte is valid this cycle |
| data_i | input | 8 | Byte to substitute |
| mode_i | input | 1 | 0 = forward, 1 = backward |
| valid_o | output | 1 | Result byte is valid |
| data_o | output | 8 | Substituted byte |

## Verification
The bench builds the unit with its default parameters: two lanes, each 4 bits wide. With these values every one of the 256 byte values can be tried in both directions. The whole forward image can therefore be collected at the output ports and checked for repeated values, and each collected result can be fed back in backward mode to check that it returns its original byte. Random traffic changes the direction bit and the valid bit from cycle to cycle, which checks that the direction is sampled along with its byte and that results are delivered with gaps and back to back. A reset asserted in the middle of traffic checks that the outputs clear at once.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BYTE_W = NIB_W * LANES;
  localparam int unsigned NIB_N  = 1 << NIB_W;

  typedef logic [NIB_W-1:0] nib_t;
  typedef enum logic {MODE_FWD = 1'b0, MODE_BWD = 1'b1} mode_e;

  // box 0 = upper half (A), box 1 = lower half (B)
  function automatic nib_t box_fwd(input int unsigned id, input nib_t x);
    nib_t r;
    if (id == 0) begin
      case (x)
        4'h0: r = 4'h7; 4'h1: r = 4'hC; 4'h2: r = 4'h0; 4'h3: r = 4'h9;
        4'h4: r = 4'hE; 4'h5: r = 4'h3; 4'h6: r = 4'hA; 4'h7: r = 4'h5;
        4'h8: r = 4'h1; 4'h9: r = 4'hF; 4'hA: r = 4'h4; 4'hB: r = 4'hB;
        4'hC: r = 4'h8; 4'hD: r = 4'h2; 4'hE: r = 4'hD; default: r = 4'h6;
      endcase
    end else begin
      case (x)
        4'h0: r = 4'hB; 4'h1: r = 4'h2; 4'h2: r = 4'hE; 4'h3: r = 4'h8;
        4'h4: r = 4'h0; 4'h5: r = 4'hD; 4'h6: r = 4'h5; 4'h7: r = 4'h3;
        4'h8: r = 4'hF; 4'h9: r = 4'h6; 4'hA: r = 4'hA; 4'hB: r = 4'h1;
        4'hC: r = 4'hC; 4'hD: r = 4'h9; 4'hE: r = 4'h4; default: r = 4'h7;
      endcase
    end
    return r;
  endfunction

  // inverse found by search over the forward table
  function automatic nib_t box_inv(input int unsigned id, input nib_t y);
    nib_t r;
    r = '0;
    for (int unsigned i = 0; i < NIB_N; i++) begin
      if (box_fwd(id, nib_t'(i)) == y) r = nib_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/sbx_stage_reg.sv
module sbx_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/sbx_nib_lane.sv
module sbx_nib_lane
  import sbx_pkg::*;
#(
  parameter int unsigned BOX_ID = 0
) (
  input  logic bwd_i,
  input  nib_t nib_i,
  output nib_t nib_o
);
  nib_t fwd_res, inv_res;

  always_comb begin
    fwd_res = box_fwd(BOX_ID, nib_i);
    inv_res = box_inv(BOX_ID, nib_i);
    nib_o   = bwd_i ? inv_res : fwd_res;
  end
endmodule

// File: rtl/nibble_sbox.sv
module nibble_sbox
  import sbx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              mode_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned IN_W = BYTE_W + 1;

  logic            in_vld;
  logic [IN_W-1:0] in_q;
  logic [BYTE_W-1:0] sub_byte;

  // mode travels with its byte
  sbx_stage_reg #(.W(IN_W)) u_in_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (valid_i),
    .d_i   ({mode_i, data_i}),
    .vld_o (in_vld),
    .q_o   (in_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // top lane uses box 0 (A), lower lanes count upward
    sbx_nib_lane #(.BOX_ID(LANES - 1 - g)) u_lane (
      .bwd_i(in_q[BYTE_W]),
      .nib_i(in_q[g*NIB_W +: NIB_W]),
      .nib_o(sub_byte[g*NIB_W +: NIB_W])
    );
  end

  sbx_stage_reg #(.W(BYTE_W)) u_out_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (in_vld),
    .d_i   (sub_byte),
    .vld_o (valid_o),
    .q_o   (data_o)
  );
endmodule

// File: rtl/nibble_sbox_chk.sv
module nibble_sbox_chk
  import sbx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [BYTE_W-1:0] data_i,
  input logic              mode_i,
  input logic              valid_o,
  input logic [BYTE_W-1:0] data_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst == 2'd2 |-> valid_o == $past(valid_i, 2)); // R1

  AST_FWD_UNDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && valid_o && !$past(mode_i, 2)) |->
      {box_inv(0, data_o[7:4]), box_inv(1, data_o[3:0])} == $past(data_i, 2)); // R3

  AST_BWD_UNDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && valid_o && $past(mode_i, 2)) |->
      {box_fwd(0, data_o[7:4]), box_fwd(1, data_o[3:0])} == $past(data_i, 2)); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && !$past(valid_i, 2)) |-> $stable(data_o)); // R8
endmodule

bind nibble_sbox nibble_sbox_chk u_chk (.*);

// File: tb/nibble_sbox_test.sv
`timescale 1ns/1ps
module nibble_sbox_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       mode_i = 1'b0;
  logic       valid_o;
  logic [7:0] data_o;

  int checks = 0;
  int fails  = 0;

  logic       hv0 = 0, hv1 = 0, hm0 = 0, hm1 = 0, hr0 = 0, hr1 = 0;
  logic [7:0] hd0 = 0, hd1 = 0, hx0 = 0, hx1 = 0;
  logic [7:0] obs_f [256];
  logic       collect = 0;

  always #2.5 clk_i = ~clk_i;

  nibble_sbox uut (.*);

  function automatic logic [3:0] tb_fwd(input int b, input logic [3:0] x);
    logic [3:0] ta [16] = '{4'h7,4'hC,4'h0,4'h9,4'hE,4'h3,4'hA,4'h5,
                            4'h1,4'hF,4'h4,4'hB,4'h8,4'h2,4'hD,4'h6};
    logic [3:0] tb [16] = '{4'hB,4'h2,4'hE,4'h8,4'h0,4'hD,4'h5,4'h3,
                            4'hF,4'h6,4'hA,4'h1,4'hC,4'h9,4'h4,4'h7};
    return (b == 0) ? ta[x] : tb[x];
  endfunction

  function automatic logic [3:0] tb_inv(input int b, input logic [3:0] y);
    logic [3:0] r = '0;
    for (int i = 0; i < 16; i++) if (tb_fwd(b, 4'(i)) == y) r = 4'(i);
    return r;
  endfunction

  function automatic logic [7:0] tb_exp(input logic [7:0] d, input logic m);
    return m ? {tb_inv(0, d[7:4]), tb_inv(1, d[3:0])}
             : {tb_fwd(0, d[7:4]), tb_fwd(1, d[3:0])};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // x: round-trip origin, r: round-trip flag
  task automatic step(input logic v, input logic [7:0] d, input logic m,
                      input logic r = 0, input logic [7:0] x = 0);
    @(negedge clk_i);
    chk("R1 valid_o", {7'd0, valid_o}, {7'd0, hv1});
    if (hv1) begin
      chk(hm1 ? "R4/R5/R9 bwd data" : "R2/R3/R5/R9 fwd data", data_o, tb_exp(hd1, hm1));
      if (hr1) chk("R7 round trip", data_o, hx1);
      if (collect && !hm1) obs_f[hd1] = data_o;
    end
    hv1 = hv0; hd1 = hd0; hm1 = hm0; hr1 = hr0; hx1 = hx0;
    hv0 = v;   hd0 = d;   hm0 = m;   hr0 = r;   hx0 = x;
    valid_i = v; data_i = d; mode_i = m;
  endtask

  task automatic flush();
    step(0, 8'h00, 0);
    step(0, 8'h00, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] last;
    bit seen [256];
    void'($urandom(32'h1d2c3b4a));
    #1;
    @(negedge clk_i);
    chk("R6 reset valid_o", {7'd0, valid_o}, 8'h00);
    chk("R6 reset data_o", data_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed: isolated fwd/bwd, nibble placement
    step(1, 8'h0F, 0); flush();
    step(1, 8'hF0, 1); flush();
    step(1, 8'h12, 0); step(0, 8'h34, 1); step(0, 8'h00, 0);
    last = data_o;
    step(0, 8'h55, 1); chk("R8 hold idle", data_o, last);
    step(0, 8'hAA, 0); chk("R8 hold idle", data_o, last);

    // R5: mode flips right after capture
    step(1, 8'hC3, 0); step(0, 8'h00, 1); step(0, 8'h00, 1); step(0, 8'h00, 0);

    // exhaustive forward, back to back (R9), collect image
    collect = 1;
    for (int i = 0; i < 256; i++) step(1, 8'(i), 0);
    flush();
    collect = 0;
    foreach (seen[i]) seen[i] = 0;
    for (int i = 0; i < 256; i++) seen[obs_f[i]] = 1;
    for (int i = 0; i < 256; i++) chk("R7 permutation hit", {7'd0, seen[i]}, 8'h01);

    // exhaustive backward
    for (int i = 0; i < 256; i++) step(1, 8'(i), 1);
    flush();

    // round trip through the ports
    for (int i = 0; i < 256; i++) step(1, obs_f[i], 1, 1, 8'(i));
    flush();

    // random traffic
    for (int k = 0; k < 2000; k++)
      step(1'($urandom % 4 != 0), 8'($urandom), 1'($urandom));
    flush();

    // async reset during traffic
    step(1, 8'h5A, 0); step(1, 8'hA5, 1);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R6 async clear valid_o", {7'd0, valid_o}, 8'h00);
    chk("R6 async clear data_o", data_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1; valid_i = 0;
    hv0 = 0; hv1 = 0; hr0 = 0; hr1 = 0;
    step(1, 8'h81, 1); flush();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule